// File: doc/BRIEF.md
# Slot-Table Thread Issue Scheduler

This block decides, on every clock, which hardware thread owns the next pipeline issue cycle. A circular table of thread numbers is walked one entry per clock. The walk wraps at a programmable length. A thread's guaranteed share of the issue bandwidth is the number of table entries that name it divided by the table length. Because the issuing thread can change on each clock, a context switch costs nothing.

When the thread named by the current entry cannot run, the cycle goes to a fallback thread chosen by a control input, and a flag marks the reassignment so that idle slots can be counted. If the fallback thread cannot run either, no issue is offered in that cycle.

The issue output is offered once per cycle with no back-pressure. The consuming pipeline takes every valid issue, so there is no ready input. The table write port, the length write port, the runnable flags and the fallback thread number are plain control inputs. The issue outputs are combinational from the registered table position and the current runnable flags.

Top module: `slot_sched_top`

## Requirements
- R1: After reset the table length is NUM_THREADS (8). Table entry i holds thread i mod NUM_THREADS. The position is entry 0, so the first issue names thread 0 when that thread can run.
- R2: When the thread in the current entry can run, the outputs are issue_valid=1, issue_tid equal to that thread, and issue_reassigned=0.
- R3: The position moves forward by exactly one entry per clock. After entry length-1 it returns to entry 0.
- R4: Over any window of a whole number of table rounds with all threads runnable, each thread gets entries/length of the issue cycles. Example: the 10-entry table 1,2,1,3,1,2,1,4,1,5 gives thread 1 50 of 100 cycles, thread 2 20, and threads 3, 4 and 5 10 each.
- R5: When the entry's thread cannot run but the fallback thread (fallback_tid) can, the outputs are issue_valid=1, issue_tid=fallback_tid and issue_reassigned=1.
- R6: When neither the entry's thread nor the fallback thread can run, the outputs are issue_valid=0, issue_tid=0 and issue_reassigned=0.
- R7: A table write (entry tbl_wr_addr, thread tbl_wr_tid) takes effect at the clock edge on which it is presented. Any read of that entry in a later cycle, including the very next one, returns the new thread.
- R8: A length write takes effect at its clock edge. The edge that carries the write still moves the position using the old length. If the new length is at or below the next position, the position returns to entry 0 on the following edge.
- R9: A written length of 0 is stored as 1. A written length above MAX_SLOTS (32) is stored as MAX_SLOTS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Write one table entry |
| tbl_wr_addr | input | 5 | Entry index to write |
| tbl_wr_tid | input | 3 | Thread number stored in the entry |
| len_wr_en | input | 1 | Write the table length |
| len_wr_val | input | 6 | New table length (clamped to 1..32) |
| runnable | input | 8 | Per-thread runnable flags, bit n for thread n |
| fallback_tid | input | 3 | Thread that receives idle slots |
| issue_valid | output | 1 | An issue cycle is granted this clock |
| issue_tid | output | 3 | Thread granted the cycle (0 when not valid) |
| issue_reassigned | output | 1 | The grant went to the fallback thread |

## Verification
A behavioural model in the bench holds its own table, length and position and predicts the three issue outputs on every clock. The table is first walked in its reset round-robin order, which shows that stepping and wrap work. It is then rewritten to an uneven 10-entry pattern and the grants are counted per thread, which separates a correct share from an off-by-one length or a skipped entry. Runnable masks that remove the slot thread alone, and then both the slot thread and the fallback thread, separate reassignment from an idle cycle. Length writes of 0, 3 (below the current position) and 50, plus a write to the entry about to be read, test clamping, forced wrap and immediate table visibility.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;
  localparam int DEF_THREADS = 8;
  localparam int DEF_SLOTS   = 32;

  typedef enum logic [1:0] {
    GRANT_NONE     = 2'd0,
    GRANT_OWN      = 2'd1,
    GRANT_FALLBACK = 2'd2
  } grant_kind_e;
endpackage

// File: rtl/slot_table.sv
module slot_table #(
  parameter int NUM_THREADS = 8,
  parameter int MAX_SLOTS   = 32,
  localparam int TID_W = $clog2(NUM_THREADS),
  localparam int PTR_W = $clog2(MAX_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_addr,
  input  logic [TID_W-1:0] wr_tid,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [TID_W-1:0] rd_tid
);
  logic [TID_W-1:0] mem [MAX_SLOTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_SLOTS; i++) mem[i] <= TID_W'(i % NUM_THREADS);
    end else if (wr_en) begin
      mem[wr_addr] <= wr_tid;
    end
  end

  assign rd_tid = mem[rd_addr];

  // R7
  wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_tid));
endmodule

// File: rtl/slot_pointer.sv
module slot_pointer #(
  parameter int MAX_SLOTS   = 32,
  parameter int NUM_THREADS = 8,
  localparam int PTR_W = $clog2(MAX_SLOTS),
  localparam int LEN_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_wr_en,
  input  logic [LEN_W-1:0] len_wr_val,
  output logic [PTR_W-1:0] ptr_q
);
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] len_clamped;
  logic [LEN_W-1:0] ptr_plus;

  always_comb begin
    if (len_wr_val == '0)                          len_clamped = LEN_W'(1);
    else if (len_wr_val > LEN_W'(MAX_SLOTS))       len_clamped = LEN_W'(MAX_SLOTS);
    else                                           len_clamped = len_wr_val;
  end

  assign ptr_plus = {1'b0, ptr_q} + LEN_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      len_q <= LEN_W'(NUM_THREADS);
    end else begin
      ptr_q <= (ptr_plus >= len_q) ? '0 : ptr_plus[PTR_W-1:0];
      if (len_wr_en) len_q <= len_clamped;
    end
  end

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q != '0) |-> ({1'b0, ptr_q} == {1'b0, $past(ptr_q)} + LEN_W'(1)));
  // R8
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q <= {1'b0, ptr_q}) |=> (ptr_q == '0));
  // R9
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q >= LEN_W'(1)) && (len_q <= LEN_W'(MAX_SLOTS)));
endmodule

// File: rtl/issue_select.sv
module issue_select
  import slot_sched_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TID_W-1:0]       slot_tid,
  input  logic [NUM_THREADS-1:0] runnable,
  input  logic [TID_W-1:0]       fallback_tid,
  output logic                   issue_valid,
  output logic [TID_W-1:0]       issue_tid,
  output logic                   issue_reassigned
);
  grant_kind_e kind;

  always_comb begin
    if (runnable[slot_tid])          kind = GRANT_OWN;
    else if (runnable[fallback_tid]) kind = GRANT_FALLBACK;
    else                             kind = GRANT_NONE;
  end

  always_comb begin
    unique case (kind)
      GRANT_OWN: begin
        issue_valid = 1'b1; issue_tid = slot_tid; issue_reassigned = 1'b0;
      end
      GRANT_FALLBACK: begin
        issue_valid = 1'b1; issue_tid = fallback_tid; issue_reassigned = 1'b1;
      end
      default: begin
        issue_valid = 1'b0; issue_tid = '0; issue_reassigned = 1'b0;
      end
    endcase
  end

  // R2
  own_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !issue_reassigned) |-> (runnable[issue_tid] && issue_tid == slot_tid));
  // R5
  fallback_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_reassigned |-> (issue_valid && issue_tid == fallback_tid && !runnable[slot_tid]));
  // R6
  idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> (!runnable[slot_tid] && !runnable[fallback_tid] && issue_tid == '0));
endmodule

// File: rtl/slot_sched_top.sv
module slot_sched_top
  import slot_sched_pkg::*;
#(
  parameter int NUM_THREADS = DEF_THREADS,
  parameter int MAX_SLOTS   = DEF_SLOTS,
  localparam int TID_W = $clog2(NUM_THREADS),
  localparam int PTR_W = $clog2(MAX_SLOTS),
  localparam int LEN_W = PTR_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tbl_wr_en,
  input  logic [PTR_W-1:0]       tbl_wr_addr,
  input  logic [TID_W-1:0]       tbl_wr_tid,
  input  logic                   len_wr_en,
  input  logic [LEN_W-1:0]       len_wr_val,
  input  logic [NUM_THREADS-1:0] runnable,
  input  logic [TID_W-1:0]       fallback_tid,
  output logic                   issue_valid,
  output logic [TID_W-1:0]       issue_tid,
  output logic                   issue_reassigned
);
  logic [PTR_W-1:0] ptr;
  logic [TID_W-1:0] slot_tid;

  slot_pointer #(.MAX_SLOTS(MAX_SLOTS), .NUM_THREADS(NUM_THREADS)) u_ptr (
    .clk(clk), .rst_n(rst_n), .len_wr_en(len_wr_en), .len_wr_val(len_wr_val),
    .ptr_q(ptr)
  );

  slot_table #(.NUM_THREADS(NUM_THREADS), .MAX_SLOTS(MAX_SLOTS)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr_en), .wr_addr(tbl_wr_addr),
    .wr_tid(tbl_wr_tid), .rd_addr(ptr), .rd_tid(slot_tid)
  );

  issue_select #(.NUM_THREADS(NUM_THREADS)) u_sel (
    .clk(clk), .rst_n(rst_n), .slot_tid(slot_tid), .runnable(runnable),
    .fallback_tid(fallback_tid), .issue_valid(issue_valid),
    .issue_tid(issue_tid), .issue_reassigned(issue_reassigned)
  );
endmodule

// File: tb/tb_slot_sched_top.sv
module tb_slot_sched_top;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 8;
  localparam int MS = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tbl_wr_en = 1'b0;
  logic [4:0] tbl_wr_addr = '0;
  logic [2:0] tbl_wr_tid = '0;
  logic       len_wr_en = 1'b0;
  logic [5:0] len_wr_val = '0;
  logic [7:0] runnable = 8'hFF;
  logic [2:0] fallback_tid = '0;
  logic       issue_valid;
  logic [2:0] issue_tid;
  logic       issue_reassigned;

  int vectors = 0;
  int miscompares = 0;
  int m_tbl [MS];
  int m_len;
  int m_ptr;
  int grants [NT];
  bit counting = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_sched_top dut (
    .clk(clk), .rst_n(rst_n), .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr),
    .tbl_wr_tid(tbl_wr_tid), .len_wr_en(len_wr_en), .len_wr_val(len_wr_val),
    .runnable(runnable), .fallback_tid(fallback_tid), .issue_valid(issue_valid),
    .issue_tid(issue_tid), .issue_reassigned(issue_reassigned)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
    summary();
  end

  task automatic check(string req, int act, int exp, string what);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one clock: compare outputs, advance the model, release strobes
  task automatic cycle();
    int s, ev, et, er;
    #1;
    s = m_tbl[m_ptr];
    if (runnable[s])                 begin ev = 1; et = s;            er = 0; end
    else if (runnable[fallback_tid]) begin ev = 1; et = fallback_tid; er = 1; end
    else                             begin ev = 0; et = 0;            er = 0; end
    check(cur_req, int'(issue_valid), ev, "issue_valid");
    check(cur_req, int'(issue_tid), et, "issue_tid");
    check(cur_req, int'(issue_reassigned), er, "issue_reassigned");
    if (counting && issue_valid) grants[issue_tid]++;
    @(posedge clk);
    if (tbl_wr_en) m_tbl[tbl_wr_addr] = tbl_wr_tid;
    m_ptr = (m_ptr + 1 >= m_len) ? 0 : m_ptr + 1;
    if (len_wr_en) m_len = (len_wr_val == 0) ? 1 : (len_wr_val > MS) ? MS : int'(len_wr_val);
    @(negedge clk);
    tbl_wr_en = 1'b0;
    len_wr_en = 1'b0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    int pat [10] = '{1, 2, 1, 3, 1, 2, 1, 4, 1, 5};
    for (int i = 0; i < MS; i++) m_tbl[i] = i % NT;
    m_len = NT;
    m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state: first issue is thread 0
    cur_req = "R1";
    #1;
    check("R1", int'(issue_tid), 0, "first issue_tid after reset");
    cycle();

    // R3 round-robin stepping and wrap with reset table
    cur_req = "R3";
    run(16);

    // R7 rewrite entries 0..9 while walking; R2 own grants
    cur_req = "R7";
    for (int i = 0; i < 10; i++) begin
      tbl_wr_en = 1'b1; tbl_wr_addr = 5'(i); tbl_wr_tid = 3'(pat[i]);
      cycle();
    end
    cur_req = "R2";
    len_wr_en = 1'b1; len_wr_val = 6'd10;
    cycle();
    run(20);

    // R4 bandwidth share over ten rounds
    cur_req = "R4";
    for (int t = 0; t < NT; t++) grants[t] = 0;
    counting = 1;
    run(100);
    counting = 0;
    check("R4", grants[1], 50, "thread 1 grants");
    check("R4", grants[2], 20, "thread 2 grants");
    check("R4", grants[3], 10, "thread 3 grants");
    check("R4", grants[4], 10, "thread 4 grants");
    check("R4", grants[5], 10, "thread 5 grants");

    // R5 fallback receives thread 1 slots
    cur_req = "R5";
    runnable = 8'hFD; fallback_tid = 3'd6;
    run(20);
    // R6 fallback also blocked
    cur_req = "R6";
    runnable = 8'hBD;
    run(20);
    fallback_tid = 3'd1;
    run(10);
    runnable = 8'hFF; fallback_tid = 3'd0;

    // R8 shrink length while position is high
    cur_req = "R8";
    while (m_ptr != 8) cycle();
    len_wr_en = 1'b1; len_wr_val = 6'd3;
    cycle();
    cycle();
    check("R8", m_ptr, 0, "model position after shrink");
    #1 check("R8", int'(issue_tid), m_tbl[0], "issue after forced wrap");
    run(10);

    // R9 clamp of zero and oversize length
    cur_req = "R9";
    len_wr_en = 1'b1; len_wr_val = 6'd0;
    cycle();
    run(6);
    check("R9", m_len, 1, "model length for zero write");
    len_wr_en = 1'b1; len_wr_val = 6'd50;
    cycle();
    run(70);

    // R7 write the entry that is read on the very next cycle
    cur_req = "R7";
    tbl_wr_en = 1'b1; tbl_wr_addr = 5'((m_ptr + 1 >= m_len) ? 0 : m_ptr + 1); tbl_wr_tid = 3'd7;
    cycle();
    #1 check("R7", int'(issue_tid), 7, "next-cycle issue after write");
    run(40);

    summary();
  end
endmodule